// File: doc/BRIEF.md
# Programmable Multi-Operand Compressor Adder

This block adds up to five 24-bit operands and eight single-bit injection terms in one hard carry-save structure. It is built from eight identical compression slices. Each slice owns three result columns and takes sixteen input bits: three bits from each of the five operands, plus one injection bit at its lowest column. That gives 128 input bits. Each slice returns six bits: three of a sum row and three of a carry row, 48 output bits in all. Neighbouring slices pass a four-bit group of column carries upward, so a carry produced at a slice's top column reaches the next slice.

A per-bit enable mask sets any unused input bit to zero. The same tree can then sum two operands, five operands, a partial-product array from a multiplier front end, or a sparse mix of these. The injection bits supply the +1 terms that two's-complement negation needs. One configuration bit cuts the array into two independent four-slice halves. Another bypasses the final carry-propagate adder, so the caller receives the redundant sum/carry pair instead of a resolved total. The result is registered, so it appears one clock after the input is presented.

Top module: `mopadd_tree`

## Requirements
- R1: While `rst` is high at a clock edge, the registers clear: after that edge `out_valid`, `out_sum` and `out_carry` are all zero.
- R2: Operand k (k = 0..4) sits in `in_bits[24k+23:24k]` with weight 2^0 at its lowest bit. Injection bit `in_bits[120+s]` (s = 0..7) adds 2^(3s).
- R3: An input bit whose `in_mask` bit is 0 contributes nothing to the result. Mask bit i governs `in_bits[i]`.
- R4: With `cfg_split`=0 and `cfg_bypass`=0, `out_sum` is the masked total modulo 2^24 and `out_carry` is zero.
- R5: With `cfg_split`=0 and `cfg_bypass`=1, (`out_sum` + `out_carry`) modulo 2^24 equals the masked total modulo 2^24.
- R6: With `cfg_split`=1 and `cfg_bypass`=0, `out_sum[11:0]` is the total of the masked bits in columns 0..11, modulo 2^12. `out_sum[23:12]` is the total of the masked bits in columns 12..23, taken relative to column 12, modulo 2^12. No carry crosses from the low half to the high half.
- R7: With `cfg_split`=1 and `cfg_bypass`=1, each half's sum field plus its carry field, modulo 2^12, equals that half's total as defined in R6, and `out_carry[12]` is zero.
- R8: `out_valid` after a clock edge equals `in_valid` at that edge. The data outputs then reflect the inputs and configuration sampled at that edge.
- R9: When `in_valid` is low at an edge, `out_sum` and `out_carry` keep their values.
- R10: With every input and mask bit set, every column overflows and its carries cross every slice link. The resolved result is then 0x249244 unsplit and 0x244244 split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid; the output register loads only when this is high |
| in_bits | input | 128 | Five 24-bit operands followed by eight injection bits |
| in_mask | input | 128 | Per-bit enable; 0 forces the matching input bit to zero |
| cfg_split | input | 1 | 1 runs the array as two independent 12-column halves |
| cfg_bypass | input | 1 | 1 skips the final adder and returns the sum and carry rows |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_sum | output | 24 | Resolved total, or the sum row when the final adder is bypassed |
| out_carry | output | 24 | Carry row when bypassed, zero otherwise |

## Verification
The bench aims at the half boundary in several ways. An operand of 0x000FFF plus one injection gives 0x001000 when the array is joined and zero when it is split. A design that leaks a carry across the cut would show a stray bit 12. A design that drops the link when the array is joined would lose the carry. Full-scale all-ones words overflow every column. A missing or misrouted slice-to-slice carry, or a wrong injection weight, would then move the result away from 0x249244. Masked words, including a mask that keeps a single operand, catch a design that reads raw inputs. Hold cycles, where the inputs change while `in_valid` is low, catch an output register that loads without the valid bit.

// File: rtl/mopadd_pkg.sv
package mopadd_pkg;
  // operand rows fed to every slice (plus one injection row)
  localparam int ROWS  = 5;
  // carry-save levels whose top-column carries cross a slice edge
  localparam int LINKS = 4;

  typedef struct packed {
    logic split;
    logic bypass;
  } mopadd_cfg_t;
endpackage

// File: rtl/mopadd_slice.sv
module mopadd_slice
  import mopadd_pkg::*;
#(
  parameter int COLW = 3
) (
  input  logic [ROWS*COLW-1:0] row_bits,
  input  logic                 inj,
  input  logic [LINKS-1:0]     cin,
  output logic [LINKS-1:0]     cout,
  output logic [COLW-1:0]      sum_row,
  output logic [COLW-1:0]      car_row
);

  // 3:2 counter across a column group: returns {carry, sum}
  function automatic logic [2*COLW-1:0] csa3(input logic [COLW-1:0] a,
                                             input logic [COLW-1:0] b,
                                             input logic [COLW-1:0] c);
    logic [COLW-1:0] s, cy;
    s  = a ^ b ^ c;
    cy = (a & b) | (a & c) | (b & c);
    return {cy, s};
  endfunction

  logic [COLW-1:0] rows [ROWS];
  logic [COLW-1:0] inj_v;

  for (genvar r = 0; r < ROWS; r++) begin : g_rows
    assign rows[r] = row_bits[r*COLW +: COLW];
  end

  assign inj_v = {{(COLW-1){1'b0}}, inj};

  // level 1: six rows into four
  logic [COLW-1:0] sa, ca, sb, cb;
  assign {ca, sa} = csa3(rows[0], rows[1], rows[2]);
  assign {cb, sb} = csa3(rows[3], rows[4], inj_v);

  logic [COLW-1:0] ca_sh, cb_sh;
  assign ca_sh = {ca[COLW-2:0], cin[0]};
  assign cb_sh = {cb[COLW-2:0], cin[1]};

  // level 2: four rows into three
  logic [COLW-1:0] sc, cc, cc_sh;
  assign {cc, sc} = csa3(sa, sb, ca_sh);
  assign cc_sh    = {cc[COLW-2:0], cin[2]};

  // level 3: three rows into two
  logic [COLW-1:0] sd, cd;
  assign {cd, sd} = csa3(sc, cb_sh, cc_sh);

  assign sum_row = sd;
  assign car_row = {cd[COLW-2:0], cin[3]};

  assign cout = {cd[COLW-1], cc[COLW-1], cb[COLW-1], ca[COLW-1]};

endmodule

// File: rtl/mopadd_cpa.sv
module mopadd_cpa #(
  parameter int W     = 24,
  parameter int HALFW = W/2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         split,
  output logic [W-1:0] y
);

  localparam int HIW = W - HALFW;

  logic [HALFW:0]  lo_sum;
  logic [HIW-1:0]  hi_sum;
  logic            link;

  assign lo_sum = {1'b0, a[HALFW-1:0]} + {1'b0, b[HALFW-1:0]};
  assign link   = split ? 1'b0 : lo_sum[HALFW];
  assign hi_sum = a[W-1:HALFW] + b[W-1:HALFW] + {{(HIW-1){1'b0}}, link};
  assign y      = {hi_sum, lo_sum[HALFW-1:0]};

endmodule

// File: rtl/mopadd_tree.sv
module mopadd_tree
  import mopadd_pkg::*;
#(
  parameter  int NSLICE = 8,
  parameter  int COLW   = 3,
  localparam int OUT_W  = NSLICE * COLW,
  localparam int IN_W   = ROWS * OUT_W + NSLICE,
  localparam int HALF_W = OUT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_bits,
  input  logic [IN_W-1:0]  in_mask,
  input  logic             cfg_split,
  input  logic             cfg_bypass,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sum,
  output logic [OUT_W-1:0] out_carry
);

  localparam int HALF_S = NSLICE / 2;

  mopadd_cfg_t cfg;
  assign cfg = '{split: cfg_split, bypass: cfg_bypass};

  logic [IN_W-1:0]  masked;
  assign masked = in_bits & in_mask;

  logic [LINKS-1:0] cin_a  [NSLICE];
  logic [LINKS-1:0] cout_a [NSLICE];
  logic [OUT_W-1:0] sum_vec, car_vec;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [ROWS*COLW-1:0] rb;

    for (genvar r = 0; r < ROWS; r++) begin : g_pick
      assign rb[r*COLW +: COLW] = masked[r*OUT_W + s*COLW +: COLW];
    end

    if (s == 0) begin : g_first
      assign cin_a[s] = '0;
    end else if (s == HALF_S) begin : g_cut
      assign cin_a[s] = cfg.split ? '0 : cout_a[s-1];
    end else begin : g_chain
      assign cin_a[s] = cout_a[s-1];
    end

    mopadd_slice #(.COLW(COLW)) slice_i (
      .row_bits (rb),
      .inj      (masked[ROWS*OUT_W + s]),
      .cin      (cin_a[s]),
      .cout     (cout_a[s]),
      .sum_row  (sum_vec[s*COLW +: COLW]),
      .car_row  (car_vec[s*COLW +: COLW])
    );
  end

  logic [LINKS-1:0] unused_top_cout;
  assign unused_top_cout = cout_a[NSLICE-1];

  logic [OUT_W-1:0] resolved;

  mopadd_cpa #(.W(OUT_W), .HALFW(HALF_W)) cpa_i (
    .a     (sum_vec),
    .b     (car_vec),
    .split (cfg.split),
    .y     (resolved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_carry <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sum   <= cfg.bypass ? sum_vec : resolved;
        out_carry <= cfg.bypass ? car_vec : '0;
      end
    end
  end

endmodule

// File: rtl/mopadd_tree_chk.sv
module mopadd_tree_chk #(
  parameter int OUT_W  = 24,
  parameter int HALF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             cfg_split,
  input logic             cfg_bypass,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sum,
  input logic [OUT_W-1:0] out_carry
);

  logic rst_d = 1'b0;
  always @(posedge clk) rst_d <= rst;

  // R1: an edge with reset high leaves all outputs cleared
  always @(posedge clk) begin
    if (rst_d) begin
      p_reset_zero_r1: assert (!out_valid && out_sum == '0 && out_carry == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sum) && $stable(out_carry)));

  p_resolved_nocarry_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_bypass) |=> (out_carry == '0));

  p_split_cut_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_split && cfg_bypass) |=> !out_carry[HALF_W]);

endmodule

bind mopadd_tree mopadd_tree_chk #(.OUT_W(OUT_W), .HALF_W(HALF_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .cfg_split  (cfg_split),
  .cfg_bypass (cfg_bypass),
  .out_valid  (out_valid),
  .out_sum    (out_sum),
  .out_carry  (out_carry)
);

// File: tb/mopadd_tree_tb_top.sv
`timescale 1ns/1ps
module mopadd_tree_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_bits = '0;
  logic [127:0] in_mask = '0;
  logic         cfg_split = 1'b0;
  logic         cfg_bypass = 1'b0;
  logic         out_valid;
  logic [23:0]  out_sum;
  logic [23:0]  out_carry;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mopadd_tree dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .in_mask(in_mask), .cfg_split(cfg_split), .cfg_bypass(cfg_bypass),
    .out_valid(out_valid), .out_sum(out_sum), .out_carry(out_carry)
  );

  localparam logic [127:0] ALL = {128{1'b1}};

  // {in_bits, in_mask, split, bypass, expected view}
  localparam int NV = 10;
  localparam logic [281:0] VEC [NV] = '{
    {128'h2000001, ALL, 1'b0, 1'b0, 24'h000003},
    {ALL, ALL, 1'b0, 1'b0, 24'h249244},
    {ALL, 128'h0, 1'b0, 1'b0, 24'h000000},
    {128'h01000000000000000000000000FFFFFF, ALL, 1'b0, 1'b0, 24'h000000},
    {128'h01000000000000000000000000000FFF, ALL, 1'b1, 1'b0, 24'h000000},
    {128'h01000000000000000000000000000FFF, ALL, 1'b0, 1'b0, 24'h001000},
    {ALL, ALL, 1'b0, 1'b1, 24'h249244},
    {ALL, 128'hFFFFFF000000000000, 1'b0, 1'b0, 24'hFFFFFF},
    {ALL, ALL, 1'b1, 1'b1, 24'h244244},
    {ALL, ALL, 1'b1, 1'b0, 24'h244244}
  };

  function automatic logic [23:0] model(input logic [127:0] d, input logic [127:0] m,
                                        input logic sp);
    logic [127:0] x;
    logic [31:0] full, lo, hi;
    x = d & m; full = 0; lo = 0; hi = 0;
    for (int k = 0; k < 5; k++) begin
      full += 32'(x[k*24 +: 24]);
      lo   += 32'(x[k*24 +: 12]);
      hi   += 32'(x[k*24+12 +: 12]);
    end
    for (int s = 0; s < 8; s++) begin
      if (x[120+s]) begin
        full += 32'(1) << (3*s);
        if (s < 4) lo += 32'(1) << (3*s);
        else       hi += 32'(1) << (3*s-12);
      end
    end
    return sp ? {hi[11:0], lo[11:0]} : full[23:0];
  endfunction

  function automatic logic [23:0] view(input logic sp, input logic bp);
    logic [11:0] l, h;
    if (!bp) return out_sum;
    if (!sp) return out_sum + out_carry;
    l = out_sum[11:0] + out_carry[11:0];
    h = out_sum[23:12] + out_carry[23:12];
    return {h, l};
  endfunction

  function automatic string mtag(input logic sp, input logic bp);
    if (sp && bp) return "R7";
    if (sp)       return "R6";
    if (bp)       return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] d, input logic [127:0] m,
                       input logic sp, input logic bp);
    @(negedge clk);
    in_bits = d; in_mask = m; cfg_split = sp; cfg_bypass = bp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string tag, input logic [127:0] d, input logic [127:0] m,
                         input logic sp, input logic bp, input logic [23:0] exp);
    apply(d, m, sp, bp);
    check(tag, view(sp, bp), exp);
    if (!bp) check({tag, " R4 carry zero"}, out_carry, 24'h0);
  endtask

  initial begin
    // R1: reset clears outputs even with valid input present
    in_valid = 1'b1; in_bits = ALL; in_mask = ALL;
    repeat (3) @(negedge clk);
    check("R1 valid", {23'h0, out_valid}, 24'h0);
    check("R1 sum", out_sum, 24'h0);
    check("R1 carry", out_carry, 24'h0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run_one(mtag(VEC[i][25], VEC[i][24]), VEC[i][281:154], VEC[i][153:26],
              VEC[i][25], VEC[i][24], VEC[i][23:0]);
    end

    // R2: field positions
    run_one("R2 top injection", 128'h1 << 127, ALL, 1'b0, 1'b0, 24'h200000);
    run_one("R2 operand four", 128'd5 << 96, ALL, 1'b0, 1'b0, 24'h000005);
    run_one("R2 injection col12 split", 128'h1 << 124, ALL, 1'b1, 1'b0, 24'h001000);

    // R10: full scale, every slice link carrying
    run_one("R10 joined", ALL, ALL, 1'b0, 1'b0, 24'h249244);
    run_one("R10 split", ALL, ALL, 1'b1, 1'b0, 24'h244244);

    // R3: mask isolation — only masked-in bits count
    run_one("R3 single bit", ALL, 128'h1 << 50, 1'b0, 1'b0, 24'h000004);

    // R7: cut carry bit in split bypass
    apply(ALL, ALL, 1'b1, 1'b1);
    check("R7 carry bit12", {23'h0, out_carry[12]}, 24'h0);

    // R8: valid follows with one cycle latency
    @(negedge clk);
    in_bits = 128'h7; in_mask = ALL; cfg_split = 1'b0; cfg_bypass = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R8 valid high", {23'h0, out_valid}, 24'h1);
    check("R8 data", out_sum, 24'h000007);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 valid low", {23'h0, out_valid}, 24'h0);

    // R9: outputs hold while valid is low and inputs change
    in_bits = ALL; cfg_bypass = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 sum hold", out_sum, 24'h000007);
    check("R9 carry hold", out_carry, 24'h0);

    // random operands and masks in every mode
    for (int md = 0; md < 4; md++) begin
      for (int n = 0; n < 100; n++) begin
        logic [127:0] d, m;
        logic sp, bp;
        sp = md[1]; bp = md[0];
        d = {$urandom, $urandom, $urandom, $urandom};
        m = {$urandom, $urandom, $urandom, $urandom};
        if (n % 4 == 0) m = ALL;
        run_one({mtag(sp, bp), " R3 random"}, d, m, sp, bp, model(d, m, sp));
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule